// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block is the sending side of an asynchronous serial port. Words arrive on a valid/ready input and land in a one-entry holding buffer. When the shifter is free, the buffered word moves into it and goes out on the serial line in this order:

- a low start bit;
- the data bits, least significant first;
- an optional extra bit;
- one or two high stop bits.

The extra bit is either a ninth data bit or a hardware parity bit. A parity bit is added on top of the data length and does not count toward it. A two-bit format input picks 8, 7 or 9 data bits, or a loopback setting. In loopback, frames go to an internal receiver-facing output and the external pin stays high.

Bit timing comes from a tick, and each bit lasts `OVS` ticks. The tick is either an internal baud strobe or the rising edges of an external clock pin, which the block synchronises internally. A break input forces the active line low for as long as software holds it. Two plain status outputs report a frame in progress and an empty buffer.

Back-pressure follows these rules. `in_ready` is high exactly when the holding buffer is empty. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. The source must hold `in_valid` and `in_data` stable until that edge.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, `txd` and `loop_txd` are 1, `busy` is 0, and `buf_empty` and `in_ready` are 1.
- R2: `in_ready` equals `buf_empty`. A word is accepted on an edge with `in_valid` and `in_ready` high. `buf_empty` is 0 after acceptance. It returns to 1 when the word moves into the shifter. While the buffer is full, a held `in_valid` waits.
- R3: A frame starts with a 0 start bit and sends the data least significant bit first, and each bit lasts `OVS` ticks. Format 2'b00 sends 8 data bits. Format 2'b01 sends `in_data[6:0]` as 7 data bits.
- R4: Format 2'b10 sends 8 data bits followed by a ninth bit. The ninth bit is the value of `bit9_par0` at the moment the word moves into the shifter. No parity bit is sent.
- R5: In formats 2'b00 and 2'b01, the parity mode is {`par_sel1`,`bit9_par0`}: 00 none, 01 odd, 10 even, 11 mark. When the mode is not none, one parity bit follows the data. Odd parity makes the total of ones odd, even parity makes it even, and mark sends a constant 1.
- R6: `two_stop`=0 sends one high stop bit, and `two_stop`=1 sends two.
- R7: `busy` rises when a word moves into the shifter. It falls in the cycle after the last stop bit ends. It stays high when a buffered word follows back-to-back.
- R8: While `brk` is 1, the active line is 0: `txd`, or `loop_txd` in loopback. When `brk` is released the line returns to the frame or idle level.
- R9: With `ext_clk_sel`=0, ticks come from `baud_tick`. With `ext_clk_sel`=1, ticks are the synchronised rising edges of `ext_clk`, and `baud_tick` has no effect.
- R10: Format 2'b11 sends nine-bit frames on `loop_txd` with the ninth bit taken from `bit9_par0`, and holds `txd` at 1.
- R11: With no frame in progress and `brk` low, both serial outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Holding buffer can accept a word |
| in_data | input | DATA_W | Word to send |
| fmt | input | 2 | Format: 00 eight, 01 seven, 10 nine, 11 loopback |
| bit9_par0 | input | 1 | Ninth data bit, or low parity select bit |
| par_sel1 | input | 1 | High parity select bit |
| two_stop | input | 1 | Two stop bits when set |
| brk | input | 1 | Force active line low |
| ext_clk_sel | input | 1 | Tick source: 0 baud strobe, 1 external clock |
| baud_tick | input | 1 | Internal baud strobe |
| ext_clk | input | 1 | External bit clock pin (asynchronous) |
| txd | output | 1 | External serial output |
| loop_txd | output | 1 | Internal loopback serial output |
| busy | output | 1 | Frame in progress |
| buf_empty | output | 1 | Holding buffer empty |

## Verification
The hardest case is a back-to-back handoff. Here the second word must already wait in the buffer at the exact edge where the previous frame's last stop bit ends, so that `busy` never drops. The bench pushes two words concurrently with decoding the line. The second push stalls on `in_ready` until the first word moves into the shifter, so it sits buffered for the whole first frame. The decoder then checks `busy` at the boundary cycle and continues straight into the second frame. A stalled external clock is also forced: the bench loads a word with the baud strobe held high and checks that the start bit does not advance.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    FMT_EIGHT = 2'b00,
    FMT_SEVEN = 2'b01,
    FMT_NINE  = 2'b10,
    FMT_LOOP  = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_MARK = 2'b11
  } par_e;

  typedef struct packed {
    fmt_e fmt;
    par_e par;
    logic bit9;
    logic two_stop;
  } tx_cfg_t;

  // value of the appended parity bit for a given mode and data ones count
  function automatic logic parity_bit(par_e mode, logic ones_odd);
    case (mode)
      PAR_ODD:  parity_bit = ~ones_odd;
      PAR_EVEN: parity_bit = ones_odd;
      default:  parity_bit = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/uart_tick_sel.sv
module uart_tick_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic baud_tick,
  input  logic ext_clk,
  output logic tick
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_rise;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[TOP-1:0], ext_clk};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_clk;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[TOP];
  end

  assign ext_rise = sync_q[TOP] & ~prev_q;
  assign tick     = ext_sel ? ext_rise : baud_tick;
endmodule

// File: rtl/uart_hold_buf.sv
module uart_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic accept;

  assign wr_ready = ~full;
  assign accept   = wr_valid & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        data <= wr_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_framer.sv
module uart_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  tx_cfg_t           cfg,
  output logic              take,
  output logic              busy,
  output logic              line
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int SUB_W   = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [FRAME_W-1:0] sh_q, vec;
  logic [LEN_W-1:0]   left_q, len;
  logic [SUB_W-1:0]   sub_q;
  logic               step, last;

  // frame assembly from the live configuration; captured when taken
  always_comb begin
    int   nd;
    logic seven, nine, has_par, extra_on, extra_val, ones;
    seven   = (cfg.fmt == FMT_SEVEN);
    nine    = (cfg.fmt == FMT_NINE) || (cfg.fmt == FMT_LOOP);
    nd      = seven ? DATA_W - 1 : DATA_W;
    has_par = !nine && (cfg.par != PAR_NONE);
    ones    = seven ? ^hold_data[DATA_W-2:0] : ^hold_data;
    extra_on  = nine | has_par;
    extra_val = nine ? cfg.bit9 : parity_bit(cfg.par, ones);
    vec    = '1;
    vec[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nd) vec[1 + i] = hold_data[i];
    end
    if (extra_on) vec[1 + nd] = extra_val;
    len = LEN_W'(1 + nd + (extra_on ? 1 : 0) + (cfg.two_stop ? 2 : 1));
  end

  assign step = busy & tick & (sub_q == SUB_LAST);
  assign last = step & (left_q == LEN_W'(1));
  assign take = hold_full & (~busy | last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
      busy   <= 1'b0;
    end else if (take) begin
      sh_q   <= vec;
      left_q <= len;
      sub_q  <= '0;
      busy   <= 1'b1;
    end else if (step) begin
      sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
      left_q <= left_q - LEN_W'(1);
      sub_q  <= '0;
      if (left_q == LEN_W'(1)) busy <= 1'b0;
    end else if (busy && tick) begin
      sub_q <= sub_q + SUB_W'(1);
    end
  end

  assign line = busy ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        fmt,
  input  logic              bit9_par0,
  input  logic              par_sel1,
  input  logic              two_stop,
  input  logic              brk,
  input  logic              ext_clk_sel,
  input  logic              baud_tick,
  input  logic              ext_clk,
  output logic              txd,
  output logic              loop_txd,
  output logic              busy,
  output logic              buf_empty
);
  logic              tick, take, hold_full, line, loop_on, active;
  logic [DATA_W-1:0] hold_data;
  tx_cfg_t           cfg;

  assign cfg.fmt      = fmt_e'(fmt);
  assign cfg.par      = par_e'({par_sel1, bit9_par0});
  assign cfg.bit9     = bit9_par0;
  assign cfg.two_stop = two_stop;

  uart_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_clk_sel),
    .baud_tick(baud_tick), .ext_clk(ext_clk), .tick(tick)
  );

  uart_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_valid(in_valid), .wr_ready(in_ready),
    .wr_data(in_data), .take(take), .full(hold_full), .data(hold_data)
  );

  uart_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_frm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold_full(hold_full),
    .hold_data(hold_data), .cfg(cfg), .take(take), .busy(busy), .line(line)
  );

  assign buf_empty = ~hold_full;
  assign loop_on   = (cfg.fmt == FMT_LOOP);
  assign active    = brk ? 1'b0 : line;
  assign txd       = loop_on ? 1'b1 : active;
  assign loop_txd  = loop_on ? active : 1'b1;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] fmt,
  input logic       brk,
  input logic       txd,
  input logic       loop_txd,
  input logic       busy,
  input logic       buf_empty,
  input logic       in_valid,
  input logic       in_ready
);
  assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> (txd && loop_txd));

  assert_break_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && fmt != 2'b11) |-> !txd);

  assert_loop_pin_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'b11) |-> txd);

  assert_accept_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !buf_empty);

  assert_busy_end_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(buf_empty));

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !brk && fmt != 2'b11) |-> !txd);
endmodule

bind uart_tx_core uart_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt(fmt), .brk(brk), .txd(txd),
  .loop_txd(loop_txd), .busy(busy), .buf_empty(buf_empty),
  .in_valid(in_valid), .in_ready(in_ready)
);

// File: tb/sim_uart_tx_core.sv
`timescale 1ns/1ps
module sim_uart_tx_core;
  logic       clk = 0, rst_n = 0;
  logic       in_valid = 0, in_ready;
  logic [7:0] in_data = 0;
  logic [1:0] fmt = 0;
  logic       bit9_par0 = 0, par_sel1 = 0, two_stop = 0, brk = 0;
  logic       ext_clk_sel = 0, baud_tick = 1, ext_clk = 0, ext_run = 0;
  logic       txd, loop_txd, busy, buf_empty;
  int         total = 0, bad = 0;

  always #5 clk = ~clk;

  uart_tx_core u0 (.*);

  initial forever begin
    repeat (4) @(negedge clk);
    if (ext_run) ext_clk = ~ext_clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int build(input [1:0] f, input p1, input b9, input two,
                               input [7:0] d, output logic [15:0] v);
    int n = 0, nd;
    logic [7:0] m;
    v = '1;
    v[n++] = 1'b0;
    nd = (f == 2'b01) ? 7 : 8;
    m = (f == 2'b01) ? {1'b0, d[6:0]} : d;
    for (int i = 0; i < nd; i++) v[n++] = d[i];
    if (f[1]) v[n++] = b9;
    else case ({p1, b9})
      2'b01: v[n++] = ~^m;
      2'b10: v[n++] = ^m;
      2'b11: v[n++] = 1'b1;
      default: ;
    endcase
    n += two ? 2 : 1;
    return n;
  endfunction

  task automatic push(input [7:0] d);
    @(negedge clk);
    in_valid = 1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic decode(input logic [15:0] exp, input int n, input bit use_loop,
                        input int per, input bit chained, input bit chk_end,
                        input bit idle_after, input string tag);
    logic [15:0] got = '1;
    int to = 0;
    if (!chained) begin
      while ((use_loop ? loop_txd : txd) !== 1'b0 && to < 3000) begin
        @(negedge clk); to++;
      end
    end
    for (int k = 0; k < n; k++) begin
      repeat (k == 0 ? per / 2 : per) @(negedge clk);
      got[k] = use_loop ? loop_txd : txd;
    end
    check(got == exp, {tag, " frame bits"}, got, exp);
    if (chk_end) begin
      repeat (per / 2 - 1) @(negedge clk);
      check(busy === 1'b1, {tag, " R7 busy in last stop"}, busy, 1);
      @(negedge clk);
      check(busy === !idle_after, {tag, " R7 busy after last stop"}, busy, !idle_after);
    end
  endtask

  task automatic send_one(input [1:0] f, input p1, input b9, input two,
                          input [7:0] d, input string tag);
    logic [15:0] v;
    int n;
    fmt = f; par_sel1 = p1; bit9_par0 = b9; two_stop = two;
    n = build(f, p1, b9, two, d, v);
    push(d);
    decode(v, n, f == 2'b11, 4, 0, 1, 1, tag);
  endtask

  task automatic t_reset;
    check(txd === 1 && loop_txd === 1, "R1 lines high", {txd, loop_txd}, 3);
    check(busy === 0, "R1 busy low", busy, 0);
    check(buf_empty === 1 && in_ready === 1, "R1 empty/ready", {buf_empty, in_ready}, 3);
  endtask

  task automatic t_formats;
    send_one(2'b00, 0, 0, 0, 8'hA5, "R3 R11 eight none");
    check(txd === 1, "R11 idle high", txd, 1);
    send_one(2'b01, 0, 1, 0, 8'hD3, "R3 R5 seven odd");
    send_one(2'b00, 1, 0, 1, 8'h71, "R5 R6 eight even two-stop");
    send_one(2'b01, 1, 1, 0, 8'h00, "R5 seven mark");
    send_one(2'b00, 0, 1, 1, 8'hFF, "R5 R6 eight odd");
  endtask

  task automatic t_nine;
    logic [15:0] v;
    int n;
    fmt = 2'b10; par_sel1 = 1; bit9_par0 = 1; two_stop = 0;
    n = build(2'b10, 1, 1, 0, 8'h3C, v);
    push(8'h3C);
    @(negedge clk);
    bit9_par0 = 0;  // after load: must not change the frame
    decode(v, n, 0, 4, 0, 1, 1, "R4 nine bit9 sampled at load");
  endtask

  task automatic t_b2b;
    logic [15:0] va, vb;
    int na, nb;
    fmt = 2'b00; par_sel1 = 0; bit9_par0 = 0; two_stop = 0;
    na = build(2'b00, 0, 0, 0, 8'h5A, va);
    nb = build(2'b00, 0, 0, 0, 8'hC3, vb);
    fork
      begin
        push(8'h5A);
        push(8'hC3);
        check(buf_empty === 0 && in_ready === 0, "R2 full after accept", buf_empty, 0);
      end
      begin
        decode(va, na, 0, 4, 0, 1, 0, "R2 R7 back-to-back first");
        decode(vb, nb, 0, 4, 1, 1, 1, "R7 back-to-back second");
      end
    join
    check(buf_empty === 1, "R2 empty after drain", buf_empty, 1);
  endtask

  task automatic t_break;
    fmt = 2'b00;
    @(negedge clk); brk = 1;
    repeat (20) @(negedge clk);
    check(txd === 0, "R8 break holds low", txd, 0);
    check(busy === 0, "R8 break no frame", busy, 0);
    brk = 0;
    @(negedge clk);
    check(txd === 1, "R8 release returns high", txd, 1);
  endtask

  task automatic t_ext;
    logic [15:0] v;
    int n, to = 0;
    ext_clk_sel = 1; baud_tick = 1; fmt = 2'b00; par_sel1 = 0; bit9_par0 = 0;
    push(8'h96);
    repeat (60) @(negedge clk);
    check(txd === 0 && busy === 1, "R9 stalled without ext clock", {txd, busy}, 1);
    ext_run = 1;
    while (busy && to < 2000) begin @(negedge clk); to++; end
    check(busy === 0, "R9 frame ends on ext clock", busy, 0);
    n = build(2'b00, 0, 0, 0, 8'h69, v);
    push(8'h69);
    decode(v, n, 0, 32, 0, 0, 1, "R9 ext clock frame");
    ext_run = 0; ext_clk_sel = 0;
    to = 0;
    while (busy && to < 500) begin @(negedge clk); to++; end
  endtask

  task automatic t_loop;
    logic [15:0] v;
    int n, lows = 0;
    fmt = 2'b11; bit9_par0 = 1; two_stop = 0; par_sel1 = 0;
    n = build(2'b11, 0, 1, 0, 8'h81, v);
    fork
      begin push(8'h81); decode(v, n, 1, 4, 0, 1, 1, "R10 loopback frame"); end
      begin repeat (70) begin @(negedge clk); if (txd !== 1) lows++; end end
    join
    check(lows == 0, "R10 txd stays high in loopback", lows, 0);
    @(negedge clk); brk = 1;
    @(negedge clk);
    check(loop_txd === 0 && txd === 1, "R8 R10 break on loop path", {loop_txd, txd}, 1);
    brk = 0; fmt = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_formats();
    t_nine();
    t_b2b();
    t_break();
    t_ext();
    t_loop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule